// File: doc/BRIEF.md
# Non-blocking Load Miss Tracker

This controller sits beside a data cache and keeps track of load misses that are still waiting for their line, so loads that hit can go on returning results while misses are pending. Each cycle it may receive one load, with its hit/miss result, its line address and a destination tag. A hit is reported back in the same cycle. A miss takes an entry in a miss queue. The line is then compared against the lines already being fetched by a small set of fill slots. A new line claims a free slot and queues one bus line-read. A line that is already being fetched joins the existing slot and causes no further bus read.

When the queue or the slots run out, the load is refused with a stall and must be presented again. A line-fill return names a slot. Every queue entry linked to that slot is released in that cycle, with its tag reported, and the slot becomes free. Data storage, cache refill writes and the bus protocol itself are handled elsewhere.

Top module: `miss_tracker`

## Requirements
- R1: After reset no queue entry or fill slot is held, `rd_valid` is 0, `done_mask` is 0, and no load is stalled.
- R2: A load with `ld_hit`=1 raises `hit_valid` with `hit_tag` equal to `ld_tag` in the same cycle and is never stalled, even while misses are outstanding.
- R3: Every accepted miss takes its own queue entry, choosing the lowest-numbered free entry. With `MQ_DEPTH` entries, that many misses to one line are all accepted.
- R4: A miss to a line held in no fill slot takes the lowest-numbered free slot and queues exactly one bus read carrying that line.
- R5: A miss to a line already held in a fill slot takes no new slot and queues no bus read. It is released together with the earlier misses to that line.
- R6: A miss is stalled (`ld_stall`=1, nothing recorded) when every queue entry is held.
- R7: A miss is stalled when every fill slot is busy and its line matches none of them. A miss to a line that does match a busy slot is still accepted in that situation.
- R8: When `fill_valid` is 1, every queue entry linked to slot `fill_slot` is flagged in `done_mask` in that same cycle. The tag of entry i appears at `done_tags[i*TAG_W +: TAG_W]`. The entries and the slot are free from the next cycle.
- R9: Bus reads are offered on `rd_valid`/`rd_line` in slot allocation order. An offer holds its line unchanged until `rd_ready` is 1.
- R10: Resources released by a fill become usable only from the following cycle. A miss presented in the fill cycle sees the occupancy from before the fill.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_valid | input | 1 | A load is presented this cycle |
| ld_hit | input | 1 | The load hit in the cache |
| ld_line | input | LINE_W | Line address of the load |
| ld_tag | input | TAG_W | Destination tag of the load |
| ld_stall | output | 1 | Load refused; present it again |
| hit_valid | output | 1 | A hit result is returned this cycle |
| hit_tag | output | TAG_W | Tag of the returned hit |
| rd_valid | output | 1 | A bus line-read is offered |
| rd_ready | input | 1 | The bus takes the offered read |
| rd_line | output | LINE_W | Line address of the offered read |
| fill_valid | input | 1 | A line fill has returned |
| fill_slot | input | log2(FS_SLOTS) | Slot the returned line belongs to |
| done_mask | output | MQ_DEPTH | Queue entries released this cycle |
| done_tags | output | MQ_DEPTH*TAG_W | Tags of all entries, field i for entry i |

## Verification
The bench builds the tracker with the default depths of four queue entries and three fill slots, so only a handful of loads are needed to fill either structure on its own or both together. The line address is narrowed to 8 bits and the tag to 4 bits. At these depths the bench can reach a stall from a full queue and a stall from full slots, and can show a matching miss accepted while all slots are busy. It also presents a miss in the same cycle as a fill. Bus reads are held back with `rd_ready` low, so the order and stability of queued reads can be observed.

// File: rtl/miss_tracker.sv
module miss_tracker #(
  parameter int MQ_DEPTH = 4,
  parameter int FS_SLOTS = 3,
  parameter int LINE_W   = 26,
  parameter int TAG_W    = 6
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      ld_valid,
  input  logic                      ld_hit,
  input  logic [LINE_W-1:0]         ld_line,
  input  logic [TAG_W-1:0]          ld_tag,
  output logic                      ld_stall,
  output logic                      hit_valid,
  output logic [TAG_W-1:0]          hit_tag,
  output logic                      rd_valid,
  input  logic                      rd_ready,
  output logic [LINE_W-1:0]         rd_line,
  input  logic                      fill_valid,
  input  logic [(FS_SLOTS>1 ? $clog2(FS_SLOTS) : 1)-1:0] fill_slot,
  output logic [MQ_DEPTH-1:0]       done_mask,
  output logic [MQ_DEPTH*TAG_W-1:0] done_tags
);
  localparam int SW = FS_SLOTS > 1 ? $clog2(FS_SLOTS) : 1;
  localparam int QW = MQ_DEPTH > 1 ? $clog2(MQ_DEPTH) : 1;
  localparam int CW = $clog2(FS_SLOTS + 1);

  logic [MQ_DEPTH-1:0] mq_v;
  logic [SW-1:0]       mq_slot [MQ_DEPTH];
  logic [TAG_W-1:0]    mq_tag  [MQ_DEPTH];
  logic [FS_SLOTS-1:0] fs_v;
  logic [LINE_W-1:0]   fs_line [FS_SLOTS];
  logic [SW-1:0]       rq      [FS_SLOTS];
  logic [CW-1:0]       rq_cnt;

  logic [FS_SLOTS-1:0] fill_clr, match;
  logic [SW-1:0]       match_idx, fs_free;
  logic [QW-1:0]       mq_free;
  logic                miss, take, new_line, pop;

  assign miss      = ld_valid & ~ld_hit;
  assign hit_valid = ld_valid & ld_hit;
  assign hit_tag   = ld_tag;

  always_comb begin
    match_idx = '0;
    fs_free   = '0;
    mq_free   = '0;
    for (int j = FS_SLOTS - 1; j >= 0; j--) begin
      fill_clr[j] = fill_valid && fill_slot == SW'(j);
      match[j]    = fs_v[j] && !fill_clr[j] && fs_line[j] == ld_line;
      if (match[j]) match_idx = SW'(j);
      if (!fs_v[j]) fs_free = SW'(j);
    end
    for (int i = MQ_DEPTH - 1; i >= 0; i--)
      if (!mq_v[i]) mq_free = QW'(i);
  end

  assign ld_stall = miss & ((&mq_v) | ((&fs_v) & ~(|match)));
  assign take     = miss & ~ld_stall;
  assign new_line = take & ~(|match);
  assign rd_valid = rq_cnt != '0;
  assign rd_line  = fs_line[rq[0]];
  assign pop      = rd_valid & rd_ready;

  for (genvar i = 0; i < MQ_DEPTH; i++) begin : g_done
    assign done_mask[i] = mq_v[i] & fill_valid & (mq_slot[i] == fill_slot);
    assign done_tags[i*TAG_W +: TAG_W] = mq_tag[i];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mq_v   <= '0;
      fs_v   <= '0;
      rq_cnt <= '0;
    end else begin
      mq_v <= (mq_v & ~done_mask) | (take ? MQ_DEPTH'(1) << mq_free : '0);
      fs_v <= (fs_v & ~fill_clr) | (new_line ? FS_SLOTS'(1) << fs_free : '0);
      rq_cnt <= rq_cnt + CW'(new_line) - CW'(pop);
      if (take) begin
        mq_slot[mq_free] <= (|match) ? match_idx : fs_free;
        mq_tag[mq_free]  <= ld_tag;
      end
      if (new_line) fs_line[fs_free] <= ld_line;
      for (int k = 0; k < FS_SLOTS - 1; k++)
        if (pop) rq[k] <= rq[k+1];
      if (new_line) rq[rq_cnt - CW'(pop)] <= fs_free;
    end
  end

  AST_HIT_NO_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    ld_valid && ld_hit |-> !ld_stall);  // R2
  AST_MISS_TAKES_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    take && !fill_valid |=> $countones(mq_v) == $past($countones(mq_v)) + 1);  // R3
  AST_STALL_KEEPS_SLOTS: assert property (@(posedge clk) disable iff (!rst_n)
    ld_stall && !fill_valid |=> fs_v == $past(fs_v));  // R7
  AST_FILL_FREES_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    fill_valid |=> !fs_v[$past(fill_slot)]);  // R8
  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && !rd_ready |=> rd_valid && $stable(rd_line));  // R9
endmodule

// File: tb/sim_miss_tracker.sv
module sim_miss_tracker;
  localparam int P  = 10;
  localparam int MQ = 4;
  localparam int FS = 3;
  localparam int LW = 8;
  localparam int TW = 4;

  logic clk = 0, rst_n = 0;
  logic ld_valid = 0, ld_hit = 0, rd_ready = 0, fill_valid = 0;
  logic [LW-1:0] ld_line = '0;
  logic [TW-1:0] ld_tag = '0;
  logic [1:0] fill_slot = '0;
  logic ld_stall, hit_valid, rd_valid;
  logic [TW-1:0] hit_tag;
  logic [LW-1:0] rd_line;
  logic [MQ-1:0] done_mask;
  logic [MQ*TW-1:0] done_tags;

  int n_chk = 0, n_bad = 0;
  logic [LW-1:0] exp_rd[$];
  int exp_done[$];

  miss_tracker #(.MQ_DEPTH(MQ), .FS_SLOTS(FS), .LINE_W(LW), .TAG_W(TW)) u0 (
    .clk, .rst_n, .ld_valid, .ld_hit, .ld_line, .ld_tag, .ld_stall,
    .hit_valid, .hit_tag, .rd_valid, .rd_ready, .rd_line,
    .fill_valid, .fill_slot, .done_mask, .done_tags);

  always #(P/2) clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // monitor: compares bus reads and released entries against the scoreboard
  always @(negedge clk) if (rst_n) begin
    if (rd_valid && rd_ready) begin
      if (exp_rd.size() == 0) check("R9 unexpected read", 1, 0);
      else check("R9/R4 read line order", int'(rd_line), int'(exp_rd.pop_front()));
    end
    for (int i = 0; i < MQ; i++) if (done_mask[i]) begin
      if (exp_done.size() == 0) check("R8 unexpected release", i, -1);
      else check("R8/R5 released entry,tag", i * 16 + int'(done_tags[i*TW +: TW]),
                 exp_done.pop_front());
    end
  end

  // driver: one cycle of load/fill stimulus with the expected stall
  task automatic step(input bit v, input bit h, input int line, input int tag,
                      input bit fv, input int fs, input bit exp_stall,
                      input bit new_rd, input string req);
    @(posedge clk); #1;
    ld_valid = v; ld_hit = h; ld_line = LW'(line); ld_tag = TW'(tag);
    fill_valid = fv; fill_slot = 2'(fs);
    #(P/2 - 2);
    if (v) check({req, " stall"}, int'(ld_stall), int'(exp_stall));
    if (v && h) begin
      check("R2 hit_valid", int'(hit_valid), 1);
      check("R2 hit_tag", int'(hit_tag), tag);
    end
    if (v && !h && !exp_stall && new_rd) exp_rd.push_back(LW'(line));
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) step(0, 0, 0, 0, 0, 0, 0, 0, "idle");
  endtask

  initial begin
    fork
      begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        #1;
        check("R1 rd_valid", int'(rd_valid), 0);
        check("R1 done_mask", int'(done_mask), 0);
        ld_valid = 1; #1;
        check("R1 stall", int'(ld_stall), 0);
        ld_valid = 0;

        rd_ready = 0;
        step(1, 0, 'h10, 1, 0, 0, 0, 1, "R4 new line");
        step(1, 1, 'h77, 7, 0, 0, 0, 0, "R2 hit");
        step(1, 0, 'h10, 2, 0, 0, 0, 0, "R5 secondary");
        step(1, 0, 'h20, 3, 0, 0, 0, 1, "R4 second line");
        step(1, 0, 'h30, 4, 0, 0, 0, 1, "R3 fourth entry");
        step(1, 0, 'h10, 5, 0, 0, 1, 0, "R6 queue full");
        step(1, 1, 'h55, 9, 0, 0, 0, 0, "R2 hit while full");
        check("R9 held line", int'(rd_line), 'h10);
        check("R9 held valid", int'(rd_valid), 1);
        rd_ready = 1;
        idle(3);
        check("R5 one read per line", exp_rd.size(), 0);

        exp_done.push_back(0 * 16 + 1);
        exp_done.push_back(1 * 16 + 2);
        step(1, 0, 'h40, 6, 1, 0, 1, 0, "R10 fill same cycle");
        step(1, 0, 'h40, 6, 0, 0, 0, 1, "R3 reuse entry0");
        step(1, 0, 'h50, 7, 0, 0, 1, 0, "R7 slots full");
        step(1, 0, 'h20, 8, 0, 0, 0, 0, "R7 match while full");
        idle(1);
        exp_done.push_back(1 * 16 + 8);
        exp_done.push_back(2 * 16 + 3);
        step(0, 0, 0, 0, 1, 1, 0, 0, "R8 fill slot1");
        exp_done.push_back(3 * 16 + 4);
        step(0, 0, 0, 0, 1, 2, 0, 0, "R8 fill slot2");
        exp_done.push_back(0 * 16 + 6);
        step(0, 0, 0, 0, 1, 0, 0, 0, "R8 fill slot0");
        idle(2);
        check("R8 all released", exp_done.size(), 0);
        check("R8 no read left", int'(rd_valid), 0);

        rd_ready = 0;
        for (int k = 0; k < MQ; k++)
          step(1, 0, 'h60, k + 1, 0, 0, 0, k == 0, "R3 same line fill");
        step(1, 0, 'h60, 9, 0, 0, 1, 0, "R6 full again");
        rd_ready = 1;
        idle(2);
        for (int k = 0; k < MQ; k++) exp_done.push_back(k * 16 + k + 1);
        step(0, 0, 0, 0, 1, 0, 0, 0, "R5 shared fill");
        idle(2);
        check("R5 shared released", exp_done.size(), 0);
        check("R4 reads drained", exp_rd.size(), 0);
      end
      begin
        repeat (5000) @(posedge clk);
        check("watchdog expired", 1, 0);
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule